// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers 32 interrupt request lines into two processor-facing outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has its own configuration word. The word sets three things: a 5-bit priority, whether the line is captured on a rising edge or follows its level, and which output the line is routed to. A per-line mask keeps a captured request from competing. For each output, the bank picks the best unmasked pending line. Priority 0 is the most urgent, and on a tie the lower line number wins. The bank then holds that winner, and the winner's number is read from a source register.

The choice stays frozen until software writes an acknowledge bit for that output. Each output has its own acknowledge bit, so the two outputs are released independently. Acknowledging an output also clears the captured request of an edge-type winner. On the next clock the bank arbitrates again.

A parameter marks the bank as secondary, for use in a two-level cascade. In that case its `irq_o` feeds one input of a primary bank. A secondary bank has no fast routing: the routing bit is stored as 0, every line goes to `irq_o`, and `fiq_o` never rises.

Register map (8-bit byte address, 32-bit data):

| Address | Contents |
|---|---|
| 0x00 | Mask. A set bit masks the line. |
| 0x04 | Pending. Writing 1 to a bit clears it. |
| 0x08 | Normal-output source number (read only). |
| 0x0C | Fast-output source number (read only). |
| 0x10 | Acknowledge. Bit 0 is the normal output, bit 1 is the fast output. |
| 0x80 + 4·n | Configuration word of line n. |

Top module: `intc_bank`

## Requirements
- R1: After reset, the mask register reads 0xFFFFFFFF, the pending register and both source registers read 0, and both outputs are low.
- R2: The configuration word of line n is at address 0x80 + 4·n. In that word, bit 0 = 1 routes the line to the fast output, bit 1 = 1 selects edge capture (0 selects level), and bits 6:2 hold the priority. The word reads back as written, and bits 31:7 read 0.
- R3: Mask register bit n = 1 keeps line n out of arbitration. The line's pending bit still records its input.
- R4: An edge-type line sets its pending bit on a rising edge of its input. Writing 1 to that bit of the pending register clears it.
- R5: A level-type line's pending bit follows the input one cycle later. A write-1-to-clear has no effect on it while the input stays high.
- R6: Among unmasked pending lines routed to the same output, the lowest priority value wins. On equal priority, the lowest line number wins.
- R7: Two clocks after a winning request appears, `irq_o` goes high and address 0x08 reads the winner's number. Both then stay unchanged, even when a more urgent request arrives, until acknowledge bit 0 is written.
- R8: An acknowledge drops the output on the next clock and clears the pending bit of an edge-type winner. The following clock starts a new arbitration.
- R9: The fast output works like the normal one, using address 0x0C and acknowledge bit 1. Each acknowledge bit releases only its own output, and writing 3 releases both.
- R10: When no unmasked pending line is routed to an output, that output is low and its source register reads 0.
- R11: With the secondary parameter set, configuration bit 0 always reads 0, every line routes to `irq_o`, and `fiq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 32 | Interrupt request lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume the following about the inputs:
- Request lines and register writes are synchronous to the clock.
- An acknowledge is a one-cycle write strobe.
- A line's routing does not change while that line is the held winner.

The bench meets these conditions in three ways. It changes stimulus only on the falling clock edge. It issues every write as a single-cycle strobe. It writes all configuration words before raising any request line. A second, secondary instance shares the same stimulus, so the fast-routed lines show up on its normal output instead.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LINES   = 32;
    localparam int IDX_W   = $clog2(LINES);
    localparam int PRIO_W  = 5;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int NCH     = 2;
    localparam int CH_IRQ  = 0;
    localparam int CH_FIQ  = 1;

    localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IRQ_SRC = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FIQ_SRC = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h10;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              edge_mode;
        logic              to_fiq;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] src;
    } grant_t;

    function automatic logic is_cfg_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic logic [IDX_W-1:0] cfg_line(input logic [ADDR_W-1:0] a);
        return a[2 +: IDX_W];
    endfunction
endpackage

// File: rtl/intc_pending.sv
module intc_pending
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] edge_sel,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] pend
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] pend_d;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            if (edge_sel[i])
                pend_d[i] = (pend[i] & ~clr[i]) | (line_in[i] & ~prev_q[i]);
            else
                pend_d[i] = line_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= line_in;
            pend   <= pend_d;
        end
    end
endmodule

// File: rtl/intc_pick.sv
module intc_pick
    import intc_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic [N-1:0]             cand,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output logic                     found,
    output logic [$clog2(N)-1:0]     idx
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                best  = prio[i];
                idx   = ($clog2(N))'(i);
            end
        end
    end
endmodule

// File: rtl/intc_hold.sv
module intc_hold
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             found,
    input  logic [IDX_W-1:0] idx,
    input  logic             ack,
    output grant_t           grant
);
    always_ff @(posedge clk) begin
        if (rst)
            grant <= '0;
        else if (ack)
            grant <= '0;
        else if (!grant.busy && found)
            grant <= '{busy: 1'b1, src: idx};
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  line_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [LINES-1:0]             mask_q;
    line_cfg_t                    cfg_q [LINES];
    line_cfg_t                    wcfg;
    logic [LINES-1:0]             edge_sel;
    logic [LINES-1:0]             route_fiq;
    logic [LINES-1:0][PRIO_W-1:0] prio_vec;
    logic [LINES-1:0]             pend;
    logic [LINES-1:0]             w1c;
    logic [LINES-1:0]             ack_clr;
    logic [NCH-1:0]               ack_v;
    logic [NCH-1:0]               any_cand;
    logic [LINES-1:0]             cand   [NCH];
    logic                         found  [NCH];
    logic [IDX_W-1:0]             pick   [NCH];
    grant_t                       grant  [NCH];
    logic [IDX_W-1:0]             irq_src_w;
    logic [IDX_W-1:0]             fiq_src_w;

    // incoming configuration word; secondary banks drop the fast routing bit
    always_comb begin
        wcfg = line_cfg_t'(reg_wdata[CFG_W-1:0]);
        if (SECONDARY)
            wcfg.to_fiq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            for (int i = 0; i < LINES; i++)
                cfg_q[i] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_MASK)
                mask_q <= reg_wdata[LINES-1:0];
            if (is_cfg_addr(reg_addr))
                cfg_q[cfg_line(reg_addr)] <= wcfg;
        end
    end

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            edge_sel[i] = cfg_q[i].edge_mode;
            prio_vec[i] = cfg_q[i].prio;
        end
    end

    generate
        if (SECONDARY) begin : g_route_sec
            assign route_fiq = '0;
        end else begin : g_route_pri
            always_comb begin
                for (int i = 0; i < LINES; i++)
                    route_fiq[i] = cfg_q[i].to_fiq;
            end
        end
    endgenerate

    always_comb begin
        for (int c = 0; c < NCH; c++)
            ack_v[c] = reg_wr && (reg_addr == OFS_ACK) && reg_wdata[c];
        w1c = (reg_wr && reg_addr == OFS_PEND) ? reg_wdata[LINES-1:0] : '0;
        for (int i = 0; i < LINES; i++) begin
            ack_clr[i] = 1'b0;
            for (int c = 0; c < NCH; c++)
                if (ack_v[c] && grant[c].busy && grant[c].src == IDX_W'(i))
                    ack_clr[i] = 1'b1;
        end
    end

    intc_pending u_pend (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .edge_sel (edge_sel),
        .clr      (w1c | ack_clr),
        .pend     (pend)
    );

    assign cand[CH_IRQ] = pend & ~mask_q & ~route_fiq;
    assign cand[CH_FIQ] = pend & ~mask_q &  route_fiq;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            intc_pick #(.N(LINES)) u_pick (
                .cand  (cand[c]),
                .prio  (prio_vec),
                .found (found[c]),
                .idx   (pick[c])
            );
            intc_hold u_hold (
                .clk   (clk),
                .rst   (rst),
                .found (found[c]),
                .idx   (pick[c]),
                .ack   (ack_v[c]),
                .grant (grant[c])
            );
            assign any_cand[c] = |cand[c];
        end
    endgenerate

    assign irq_o     = grant[CH_IRQ].busy;
    assign fiq_o     = grant[CH_FIQ].busy;
    assign irq_src_w = grant[CH_IRQ].src;
    assign fiq_src_w = grant[CH_FIQ].src;

    always_comb begin
        reg_rdata = '0;
        if (is_cfg_addr(reg_addr))
            reg_rdata = DATA_W'(cfg_q[cfg_line(reg_addr)]);
        else begin
            case (reg_addr)
                OFS_MASK:    reg_rdata = DATA_W'(mask_q);
                OFS_PEND:    reg_rdata = DATA_W'(pend);
                OFS_IRQ_SRC: reg_rdata = DATA_W'(irq_src_w);
                OFS_FIQ_SRC: reg_rdata = DATA_W'(fiq_src_w);
                default:     reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk
    import intc_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_o,
    input logic             fiq_o,
    input logic [NCH-1:0]   ack_v,
    input logic [NCH-1:0]   any_cand,
    input logic [IDX_W-1:0] irq_src,
    input logic [IDX_W-1:0] fiq_src
);
    AST_IRQ_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack_v[0]) |=> (irq_o && $stable(irq_src))); // R7
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_v[0]) |=> !irq_o); // R8
    AST_FIQ_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (fiq_o && !ack_v[1]) |=> (fiq_o && $stable(fiq_src))); // R9
    AST_FIQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (fiq_o && ack_v[1]) |=> !fiq_o); // R9
    AST_IRQ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (irq_src == '0)); // R10
    AST_FIQ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fiq_o |-> (fiq_src == '0)); // R10
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(any_cand[0])); // R10
    AST_FIQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(fiq_o) |-> $past(any_cand[1])); // R10

    always @(posedge clk) begin
        if (!rst && SECONDARY)
            AST_SEC_NO_FIQ: assert (!fiq_o); // R11
    end
endmodule

bind intc_bank intc_bank_chk #(.SECONDARY(SECONDARY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .ack_v    (ack_v),
    .any_cand (any_cand),
    .irq_src  (irq_src_w),
    .fiq_src  (fiq_src_w)
);

// File: tb/sim_intc_bank.sv
`timescale 1ns/1ps
module sim_intc_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] line_in = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, fiq0, irq1, fiq1;
    int          nchk = 0;
    int          nfail = 0;

    always #10 clk = ~clk;   // 50 MHz

    intc_bank #(.SECONDARY(1'b0)) u0 (
        .clk(clk), .rst(rst), .line_in(line_in), .reg_wr(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd0), .irq_o(irq0), .fiq_o(fiq0));
    intc_bank #(.SECONDARY(1'b1)) u1 (
        .clk(clk), .rst(rst), .line_in(line_in), .reg_wr(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd1), .irq_o(irq1), .fiq_o(fiq1));

    // behavioural reference: bank 0 primary, bank 1 secondary
    bit [31:0] m_mask [2];
    bit [31:0] m_pend [2];
    bit [31:0] m_prev [2];
    bit [6:0]  m_cfg  [2][32];
    bit        m_busy [2][2];
    int        m_src  [2][2];

    always @(posedge clk) begin : model
        int win [2];
        int bp;
        int pr;
        bit p;
        bit [31:0] np;
        for (int m = 0; m < 2; m++) begin
            if (rst) begin
                m_mask[m] = 32'hFFFF_FFFF;
                m_pend[m] = 0;
                m_prev[m] = 0;
                for (int i = 0; i < 32; i++) m_cfg[m][i] = 0;
                for (int c = 0; c < 2; c++) begin m_busy[m][c] = 0; m_src[m][c] = 0; end
            end else begin
                for (int c = 0; c < 2; c++) begin
                    win[c] = -1;
                    bp = 99;
                    for (int i = 0; i < 32; i++) begin
                        if (m_pend[m][i] && !m_mask[m][i] && int'(m_cfg[m][i][0]) == c) begin
                            pr = int'(m_cfg[m][i][6:2]);
                            if (pr < bp) begin bp = pr; win[c] = i; end
                        end
                    end
                end
                for (int i = 0; i < 32; i++) begin
                    if (m_cfg[m][i][1]) begin
                        p = m_pend[m][i];
                        if (wr_en && addr == 8'h04 && wdata[i]) p = 0;
                        for (int c = 0; c < 2; c++)
                            if (wr_en && addr == 8'h10 && wdata[c] && m_busy[m][c] && m_src[m][c] == i) p = 0;
                        if (line_in[i] && !m_prev[m][i]) p = 1;
                        np[i] = p;
                    end else begin
                        np[i] = line_in[i];
                    end
                end
                m_prev[m] = line_in;
                m_pend[m] = np;
                for (int c = 0; c < 2; c++) begin
                    if (wr_en && addr == 8'h10 && wdata[c]) begin
                        m_busy[m][c] = 0; m_src[m][c] = 0;
                    end else if (!m_busy[m][c] && win[c] >= 0) begin
                        m_busy[m][c] = 1; m_src[m][c] = win[c];
                    end
                end
                if (wr_en && addr == 8'h00) m_mask[m] = wdata;
                if (wr_en && addr[7])
                    m_cfg[m][addr[6:2]] = (m == 1) ? {wdata[6:1], 1'b0} : wdata[6:0];
            end
        end
    end

    function automatic bit [31:0] m_read(int m, bit [7:0] a);
        if (a[7]) return {25'b0, m_cfg[m][a[6:2]]};
        case (a)
            8'h00:   return m_mask[m];
            8'h04:   return m_pend[m];
            8'h08:   return 32'(m_src[m][0]);
            8'h0C:   return 32'(m_src[m][1]);
            default: return 0;
        endcase
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(posedge clk) begin
        #15;
        if (!rst) begin
            cmp(32'(irq0), 32'(m_busy[0][0]), "R7 model irq_o u0");
            cmp(32'(fiq0), 32'(m_busy[0][1]), "R9 model fiq_o u0");
            cmp(32'(irq1), 32'(m_busy[1][0]), "R11 model irq_o u1");
            cmp(32'(fiq1), 32'(m_busy[1][1]), "R11 model fiq_o u1");
            cmp(rd0, m_read(0, addr), "R2 model read u0");
            cmp(rd1, m_read(1, addr), "R2 model read u1");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #5;
        cmp(rd0, exp, tag);
        @(negedge clk);
    endtask

    task automatic chk1(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #5;
        cmp(rd1, exp, tag);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        $display("FAIL R1 watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk(8'h00, 32'hFFFF_FFFF, "R1 mask after reset");
        cmp(32'(irq0), 0, "R1 irq_o low");
        cmp(32'(fiq0), 0, "R1 fiq_o low");
        chk(8'h08, 0, "R1 irq source zero");
        chk(8'h0C, 0, "R1 fiq source zero");
        chk(8'h04, 0, "R1 pending zero");
        // configuration words
        wr(8'h94, 32'h0E);      // line 5: edge, prio 3
        wr(8'hA4, 32'h04);      // line 9: level, prio 1
        wr(8'hB0, 32'h08);      // line 12: level, prio 2
        wr(8'hD0, 32'h08);      // line 20: level, prio 2
        wr(8'hB4, 32'h02);      // line 13: edge, prio 0
        wr(8'h9C, 32'h7F);      // line 7: fiq, edge, prio 31
        wr(8'h8C, 32'h01);      // line 3: fiq, level, prio 0
        chk(8'h94, 32'h0E, "R2 cfg readback line5");
        chk(8'h9C, 32'h7F, "R2 cfg readback line7");
        chk1(8'h9C, 32'h7E, "R11 secondary drops fiq bit");
        // R3 mask: unmask 3,5,7,9,12,20
        wr(8'h00, 32'hFFEF_ED57);
        chk(8'h00, 32'hFFEF_ED57, "R3 mask readback");
        // R4 edge capture on masked line 13, then write-1-to-clear
        line_in[13] = 1'b1;
        step(2);
        chk(8'h04, 32'h2000, "R4 edge pending set");
        cmp(32'(irq0), 0, "R3 masked line no request");
        wr(8'h04, 32'h2000);
        chk(8'h04, 0, "R4 w1c clears edge");
        line_in[13] = 1'b0;
        step(1);
        // R7 winner held
        line_in[5] = 1'b1;
        step(2);
        cmp(32'(irq0), 1, "R7 irq_o raised");
        chk(8'h08, 5, "R7 source line5");
        line_in[9] = 1'b1;
        step(2);
        chk(8'h08, 5, "R7 source frozen");
        chk(8'h04, 32'h220, "R5 level pending");
        wr(8'h04, 32'h200);
        chk(8'h04, 32'h220, "R5 w1c ignored on level");
        // R8 acknowledge
        wr(8'h10, 32'h1);
        step(1);
        chk(8'h08, 9, "R8 new winner after ack");
        chk(8'h04, 32'h200, "R8 edge winner cleared");
        // R10 idle
        line_in[5] = 1'b0;
        line_in[9] = 1'b0;
        wr(8'h10, 32'h1);
        step(1);
        cmp(32'(irq0), 0, "R10 irq_o low when idle");
        chk(8'h08, 0, "R10 source zero when idle");
        // R6 ordering
        line_in[12] = 1'b1;
        line_in[20] = 1'b1;
        step(2);
        chk(8'h08, 12, "R6 tie goes to lower line");
        line_in[12] = 1'b0;
        wr(8'h10, 32'h1);
        step(1);
        chk(8'h08, 20, "R6 remaining line wins");
        line_in[9] = 1'b1;
        wr(8'h10, 32'h1);
        step(1);
        chk(8'h08, 9, "R6 priority beats line number");
        line_in[9] = 1'b0;
        line_in[20] = 1'b0;
        wr(8'h10, 32'h1);
        step(2);
        // R9 fast output
        line_in[7] = 1'b1;
        step(2);
        cmp(32'(fiq0), 1, "R9 fiq_o raised");
        cmp(32'(irq0), 0, "R9 irq_o unaffected");
        cmp(32'(irq1), 1, "R11 secondary routes to irq");
        cmp(32'(fiq1), 0, "R11 secondary fiq_o low");
        chk(8'h0C, 7, "R9 fiq source line7");
        wr(8'h10, 32'h1);
        step(1);
        chk(8'h0C, 7, "R9 irq ack leaves fiq held");
        line_in[3] = 1'b1;
        step(2);
        chk(8'h0C, 7, "R9 fiq source frozen");
        cmp(32'(fiq1), 0, "R11 secondary fiq_o stays low");
        wr(8'h10, 32'h2);
        step(1);
        chk(8'h0C, 3, "R9 fiq next winner");
        chk(8'h04, 32'h8, "R8 fiq edge winner cleared");
        line_in[9] = 1'b1;
        step(2);
        chk(8'h08, 9, "R9 irq independent of fiq");
        line_in[3] = 1'b0;
        line_in[7] = 1'b0;
        line_in[9] = 1'b0;
        wr(8'h10, 32'h3);
        step(1);
        cmp(32'(fiq0), 0, "R9 both acked fiq low");
        cmp(32'(irq0), 0, "R9 both acked irq low");
        chk(8'h0C, 0, "R10 fiq source zero");
        chk(8'h08, 0, "R10 irq source zero");
        step(3);
        finish_run();
    end
endmodule